// File: doc/BRIEF.md
# Dual-Rail Power-Up Sequencer

This controller brings up two regulator outputs from a shared reference chain. When either rail is enabled it waits for the supply monitor to report a healthy input. It then walks the reference chain one step at a time: it latches the trim, powers the bandgap, powers the reference and current generators, and fast-charges the bypass capacitor. After that it issues a ramp-start request for each enabled rail. Every analog status arrives as a clean flag that is synchronous to the clock.

The order in which the rails start depends on when each enable arrives relative to the other rail. Rail 1 has priority unless rail 2 is already ramping. A supply dropout withdraws both ramp requests and forces the whole chain to run again once the supply recovers. Each reference step finishes on its own completion strobe, or after a programmable number of cycles if that strobe never arrives.

Top module: `pwrseq_dual_rail`

## Requirements
- R1: With both enables low, the state code is 0 on the next clock edge, and the trim strobe, bandgap, reference, bypass and both ramp outputs are all low.
- R2: When either enable is high and the block is in shutdown, it moves to state code 1. It stays in state 1, with every request low, until it samples `uv_above_i` high.
- R3: The reference chain follows a fixed order of state codes: 2 (trim strobe high), 3 (bandgap request), 4 (bandgap and reference requests), 5 (bandgap, reference and bypass charge requests), then 6, the run state (bandgap and reference requests held, bypass charge low).
- R4: In states 2 to 5, the step advances on the edge that samples its own bit of `step_done_i` high. The bits are: bit 0 trim, bit 1 bandgap, bit 2 reference, bit 3 bypass. A done bit that belongs to another step does not advance it.
- R5: A step whose done bit never arrives advances after it has spent STEP_TIMEOUT cycles in that step.
- R6: In the run state with enable 1 high, rail 1 is requested on the same edge. It never waits for rail 2.
- R7: While enable 1 is high, rail 2 does not start until rail 1 has been requested and `rail1_at_target_i` is sampled high.
- R8: If enable 2 came first and enable 1 rises before rail 2 has been requested, rail 1 starts first and rail 2 waits as in R7.
- R9: If enable 1 rises while rail 2 is already requested, rail 1 is requested on the next edge and rail 2 stays requested.
- R10: If both enables rise in the same cycle, rail 1 is requested on entry to the run state and rail 2 is not.
- R11: When `uv_below_i` is sampled high while either enable is high, both ramp requests and all reference requests drop on that edge and the state code becomes 1. Once `uv_above_i` is seen again, the chain restarts from state 2.
- R12: Dropping one enable drops only that rail's request. The reference requests stay up while the other enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en1_i | input | 1 | Enable for rail 1 |
| en2_i | input | 1 | Enable for rail 2 |
| uv_above_i | input | 1 | Supply is above the rising threshold |
| uv_below_i | input | 1 | Supply is below the falling threshold |
| step_done_i | input | 4 | Reference step completion strobes (bit 0 trim, 1 bandgap, 2 reference, 3 bypass) |
| rail1_at_target_i | input | 1 | Rail 1 output has reached its target |
| trim_latch_o | output | 1 | Trim latch strobe, high during the trim step |
| bgap_req_o | output | 1 | Bandgap power request |
| refgen_req_o | output | 1 | Reference and current generator power request |
| bypass_chg_o | output | 1 | Bypass capacitor fast-charge request |
| rail1_ramp_o | output | 1 | Rail 1 ramp-start request |
| rail2_ramp_o | output | 1 | Rail 2 ramp-start request |
| seq_state_o | output | 3 | Sequencer state code |

## Verification
Every output comes from a register, so each result is due on the first rising edge that samples the stimulus. There are two exceptions. A missing done strobe resolves only after STEP_TIMEOUT cycles in the step. A rail 2 start that waits on rail 1 needs one extra edge, because rail 1's request must already be registered. The bench changes inputs 2 ns after an edge and reads the directed checks 2 ns after the following edge. Its cycle model advances on the same edges and is compared on every falling edge, so no check ever reads a value in the middle of a transition.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,
        PS_UVWAIT = 3'd1,
        PS_TRIM   = 3'd2,
        PS_BGAP   = 3'd3,
        PS_REFGEN = 3'd4,
        PS_BYPASS = 3'd5,
        PS_RUN    = 3'd6
    } pseq_state_e;

    localparam int unsigned NUM_REF_STEPS = 4;
    localparam int unsigned FIRST_STEP    = 2;

endpackage

// File: rtl/pwrseq_refseq.sv
module pwrseq_refseq
    import pwrseq_pkg::*;
#(
    parameter int unsigned STEP_TIMEOUT = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     any_en_i,
    input  logic                     uv_above_i,
    input  logic                     uv_below_i,
    input  logic [NUM_REF_STEPS-1:0] step_done_i,
    output pseq_state_e              state_o,
    output logic [NUM_REF_STEPS-1:0] step_req_o,
    output logic                     run_next_o
);

    localparam int unsigned CNT_W = $clog2(STEP_TIMEOUT + 1);
    localparam int unsigned LAST_STEP = FIRST_STEP + NUM_REF_STEPS - 1;

    typedef struct packed {
        pseq_state_e      state;
        logic [CNT_W-1:0] cnt;
    } refseq_regs_t;

    refseq_regs_t q, d;
    logic in_step;
    logic cur_done;
    logic timed_out;

    always_comb begin
        d         = q;
        in_step   = (int'(q.state) >= int'(FIRST_STEP)) && (int'(q.state) <= int'(LAST_STEP));
        cur_done  = 1'b0;
        for (int i = 0; i < int'(NUM_REF_STEPS); i++) begin
            if (int'(q.state) == int'(FIRST_STEP) + i) cur_done = step_done_i[i];
        end
        timed_out = (q.cnt == CNT_W'(STEP_TIMEOUT - 1));

        if (!any_en_i) begin
            d.state = PS_OFF;
        end else if (q.state == PS_OFF) begin
            d.state = PS_UVWAIT;
        end else if (uv_below_i) begin
            d.state = PS_UVWAIT;
        end else if (q.state == PS_UVWAIT) begin
            if (uv_above_i) d.state = PS_TRIM;
        end else if (in_step && (cur_done || timed_out)) begin
            d.state = pseq_state_e'(3'(q.state + 3'd1));
        end

        if ((d.state != q.state) || !in_step) d.cnt = '0;
        else                                  d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= PS_OFF;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign state_o    = q.state;
    assign run_next_o = (d.state == PS_RUN);

    // Outer steps are pulses for their own step; inner ones hold until run ends.
    for (genvar k = 0; k < int'(NUM_REF_STEPS); k++) begin : g_req
        if (k == 0 || k == int'(NUM_REF_STEPS) - 1) begin : g_own
            assign step_req_o[k] = (int'(q.state) == int'(FIRST_STEP) + k);
        end else begin : g_hold
            assign step_req_o[k] = (int'(q.state) >= int'(FIRST_STEP) + k) &&
                                   (q.state <= PS_RUN) && (q.state != PS_OFF);
        end
    end

    a_r5_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        in_step |-> (q.cnt < CNT_W'(STEP_TIMEOUT)));

    a_r2_hold_for_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == PS_UVWAIT && !uv_above_i) |=> (q.state == PS_UVWAIT || q.state == PS_OFF));

    a_r3_bgap_after_trim: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_req_o[1]) |-> ($past(q.state) == PS_TRIM));

    a_r4_done_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (in_step && cur_done && any_en_i && !uv_below_i) |=> (q.state != $past(q.state)));

endmodule

// File: rtl/pwrseq_rail_arb.sv
module pwrseq_rail_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic run_next_i,
    input  logic en1_i,
    input  logic en2_i,
    input  logic rail1_tgt_i,
    output logic rail1_ramp_o,
    output logic rail2_ramp_o
);

    typedef struct packed {
        logic r1;
        logic r2;
    } arb_regs_t;

    arb_regs_t q, d;
    logic r2_clear;

    always_comb begin
        d        = q;
        // Rail 2 may go once rail 1 is absent, settled, or rail 2 already runs.
        r2_clear = q.r2 || !en1_i || (q.r1 && rail1_tgt_i);
        d.r1     = run_next_i && en1_i;
        d.r2     = run_next_i && en2_i && r2_clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.r1 <= 1'b0;
            q.r2 <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rail1_ramp_o = q.r1;
    assign rail2_ramp_o = q.r2;

    a_r7_rail2_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.r2 && en1_i && !(q.r1 && rail1_tgt_i)) |=> !rail2_ramp_o);

    a_r6_rail1_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail2_ramp_o) |-> ($past(rail1_ramp_o) || !$past(en1_i)));

endmodule

// File: rtl/pwrseq_dual_rail.sv
module pwrseq_dual_rail
    import pwrseq_pkg::*;
#(
    parameter int unsigned STEP_TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en1_i,
    input  logic       en2_i,
    input  logic       uv_above_i,
    input  logic       uv_below_i,
    input  logic [3:0] step_done_i,
    input  logic       rail1_at_target_i,
    output logic       trim_latch_o,
    output logic       bgap_req_o,
    output logic       refgen_req_o,
    output logic       bypass_chg_o,
    output logic       rail1_ramp_o,
    output logic       rail2_ramp_o,
    output logic [2:0] seq_state_o
);

    pseq_state_e              state;
    logic [NUM_REF_STEPS-1:0] step_req;
    logic                     run_next;

    pwrseq_refseq #(.STEP_TIMEOUT(STEP_TIMEOUT)) u_refseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_en_i    (en1_i | en2_i),
        .uv_above_i  (uv_above_i),
        .uv_below_i  (uv_below_i),
        .step_done_i (step_done_i),
        .state_o     (state),
        .step_req_o  (step_req),
        .run_next_o  (run_next)
    );

    pwrseq_rail_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_next_i   (run_next),
        .en1_i        (en1_i),
        .en2_i        (en2_i),
        .rail1_tgt_i  (rail1_at_target_i),
        .rail1_ramp_o (rail1_ramp_o),
        .rail2_ramp_o (rail2_ramp_o)
    );

    assign trim_latch_o = step_req[0];
    assign bgap_req_o   = step_req[1];
    assign refgen_req_o = step_req[2];
    assign bypass_chg_o = step_req[3];
    assign seq_state_o  = state;

    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en1_i && !en2_i) |=> (seq_state_o == 3'd0 && !bgap_req_o && !rail1_ramp_o && !rail2_ramp_o));

    a_r11_dropout_rails: assert property (@(posedge clk) disable iff (!rst_n)
        uv_below_i |=> (!rail1_ramp_o && !rail2_ramp_o && !refgen_req_o));

    a_r9_late_rail1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o == 3'd6 && rail2_ramp_o && en1_i && en2_i && !uv_below_i)
            |=> (rail1_ramp_o && rail2_ramp_o));

    a_r12_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rail1_ramp_o && rail2_ramp_o && !en1_i && en2_i && !uv_below_i)
            |=> (!rail1_ramp_o && rail2_ramp_o && bgap_req_o));

endmodule

// File: tb/tb_pwrseq_dual_rail.sv
module tb_pwrseq_dual_rail;

    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en1 = 0, en2 = 0, uv_above = 0, uv_below = 0, tgt1 = 0;
    logic [3:0] done = '0;
    logic       trim_o, bg_o, ref_o, byp_o, r1_o, r2_o;
    logic [2:0] st_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwrseq_dual_rail #(.STEP_TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .en1_i(en1), .en2_i(en2),
        .uv_above_i(uv_above), .uv_below_i(uv_below), .step_done_i(done),
        .rail1_at_target_i(tgt1), .trim_latch_o(trim_o), .bgap_req_o(bg_o),
        .refgen_req_o(ref_o), .bypass_chg_o(byp_o), .rail1_ramp_o(r1_o),
        .rail2_ramp_o(r2_o), .seq_state_o(st_o)
    );

    // Behavioural model of the sequence, stepped on each rising edge.
    int m_st = 0, m_cnt = 0;
    bit m_r1 = 0, m_r2 = 0;

    always @(posedge clk) begin
        int ns;
        bit stepping;
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_r1 <= 0; m_r2 <= 0;
        end else begin
            stepping = (m_st >= 2 && m_st <= 5);
            ns = m_st;
            if (!(en1 || en2))     ns = 0;
            else if (m_st == 0)    ns = 1;
            else if (uv_below)     ns = 1;
            else if (m_st == 1)    ns = uv_above ? 2 : 1;
            else if (stepping && (done[m_st-2] || m_cnt == TMO - 1)) ns = m_st + 1;
            m_cnt <= (ns != m_st || !stepping) ? 0 : m_cnt + 1;
            m_st  <= ns;
            m_r1  <= (ns == 6) && en1;
            m_r2  <= (ns == 6) && en2 && (m_r2 || !en1 || (m_r1 && tgt1));
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("R3 model state", int'(st_o), m_st);
            chk("R3 model trim", int'(trim_o), int'(m_st == 2));
            chk("R3 model bandgap", int'(bg_o), int'(m_st >= 3 && m_st <= 6));
            chk("R3 model reference", int'(ref_o), int'(m_st >= 4 && m_st <= 6));
            chk("R3 model bypass", int'(byp_o), int'(m_st == 5));
            chk("R6 model rail1", int'(r1_o), int'(m_r1));
            chk("R7 model rail2", int'(r2_o), int'(m_r2));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic run_refs();
        for (int k = 0; k < 4; k++) begin
            done = 4'(1 << k);
            tick();
            done = '0;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk("R1 reset state", int'(st_o), 0);
        chk("R1 reset rails", int'({r1_o, r2_o, bg_o}), 0);

        // Both enables together, supply not yet valid
        en1 = 1; en2 = 1;
        tick(); chk("R2 wait state", int'(st_o), 1);
        tick(); tick(); chk("R2 still waiting", int'(st_o), 1);
        chk("R2 no requests", int'({trim_o, bg_o, r1_o}), 0);
        uv_above = 1;
        tick(); chk("R3 trim step", int'(st_o), 2); chk("R3 trim strobe", int'(trim_o), 1);
        done = 4'b0001; tick(); done = '0;
        chk("R4 trim done", int'(st_o), 3);
        done = 4'b0100; tick(); done = '0;
        chk("R4 foreign bit ignored", int'(st_o), 3);
        done = 4'b0010; tick(); done = '0;
        chk("R4 bandgap done", int'(st_o), 4);
        done = 4'b0100; tick(); done = '0;
        chk("R3 bypass step", int'(byp_o), 1);
        done = 4'b1000; tick(); done = '0;
        chk("R3 run state", int'(st_o), 6);
        chk("R10 rail1 first", int'(r1_o), 1);
        chk("R10 rail2 held", int'(r2_o), 0);
        tick(); chk("R7 rail2 still held", int'(r2_o), 0);
        tgt1 = 1;
        tick(); chk("R7 rail2 after target", int'(r2_o), 1);

        // Dropout and recovery, then timeout on trim step
        uv_below = 1; uv_above = 0;
        tick(); chk("R11 dropout state", int'(st_o), 1);
        chk("R11 rails dropped", int'({r1_o, r2_o, bg_o, ref_o}), 0);
        uv_below = 0;
        tick(); chk("R11 waits for recovery", int'(st_o), 1);
        uv_above = 1;
        tick(); chk("R11 restart from trim", int'(st_o), 2);
        repeat (TMO - 1) tick();
        chk("R5 before timeout", int'(st_o), 2);
        tick(); chk("R5 timeout advance", int'(st_o), 3);
        for (int k = 1; k < 4; k++) begin
            done = 4'(1 << k); tick(); done = '0;
        end
        chk("R11 back in run", int'(st_o), 6);
        tick(); chk("R11 both rails back", int'({r1_o, r2_o}), 3);

        // Single enable removal
        en1 = 0;
        tick(); chk("R12 rail1 dropped", int'({r1_o, r2_o}), 1);
        chk("R12 references held", int'(bg_o & ref_o), 1);
        en1 = 1;
        tick(); chk("R9 rail1 immediate", int'({r1_o, r2_o}), 3);
        en2 = 0;
        tick(); chk("R12 rail2 dropped", int'({r1_o, r2_o}), 2);
        en1 = 0;
        tick(); chk("R1 shutdown", int'(st_o), 0);
        chk("R1 all low", int'({trim_o, bg_o, ref_o, byp_o, r1_o, r2_o}), 0);

        // Enable 2 first, enable 1 before rail 2 ramps
        tgt1 = 0; en2 = 1;
        tick(); tick();
        chk("R8 in trim", int'(st_o), 2);
        en1 = 1;
        run_refs();
        chk("R8 rail1 first", int'({r1_o, r2_o}), 2);
        tgt1 = 1;
        tick(); tick(); chk("R8 rail2 after rail1", int'({r1_o, r2_o}), 3);
        en1 = 0; en2 = 0;
        tick(); chk("R1 shutdown again", int'(st_o), 0);

        // Enable 2 alone reaches run, enable 1 arrives late
        tgt1 = 0; en2 = 1;
        tick(); tick();
        run_refs();
        chk("R6 rail2 alone", int'({r1_o, r2_o}), 1);
        en1 = 1;
        tick(); chk("R9 late rail1 no wait", int'({r1_o, r2_o}), 3);
        tick(); chk("R6 rail1 held", int'(r1_o), 1);

        en1 = 0; en2 = 0;
        tick();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule